// File: doc/BRIEF.md
# Input Change Interrupt Generator for a 16-Pin Port Expander

This block raises an active-low interrupt when any pin that is set as an input moves away from a stored reference level. It sits inside a two-port, 16-pin serial-bus port expander. It receives the raw pin levels, the per-pin direction bits and one read strobe per 8-pin port. The raw levels pass through a synchronizer. The synchronized levels are compared with a per-pin reference snapshot, and the result drives a registered interrupt output.

The interrupt follows the pins rather than latching an event. If a changed input returns to its reference level before the host reads it, the interrupt releases by itself and leaves no trace. A host read of a port loads that port's current levels as its new reference. This clears that port's share of the interrupt and re-arms it for the next change. Pins set as outputs never take part in the comparison. While a pin is an output, its reference bit follows the pin, so switching the pin to input does not by itself raise an interrupt.

Top module: `gpio_chg_irq`

## Requirements
- R1: While `rst_n` is low, `irq_n` is 1 from the first clock edge onward. The reference is loaded from the synchronized pin levels, so `irq_n` stays 1 after reset is released while the pins are steady.
- R2: A `dir_in` bit of 1 marks that pin as an input. If an input pin changes on `pin_in` while no read is pending, `irq_n` goes to 0 at the third rising clock edge after the change is applied (two synchronizer stages plus the output register).
- R3: A pin whose `dir_in` bit is 0 (output) never causes `irq_n` to go low, however its level changes. With all `dir_in` bits at 0, `irq_n` stays 1.
- R4: Strobe `rd_port[0]` covers pins 7:0 and `rd_port[1]` covers pins 15:8. A one-cycle strobe loads that port's synchronized levels as its reference. If no other input mismatches, `irq_n` returns to 1 at the same clock edge.
- R5: A read of one port leaves the other port's reference unchanged, so a mismatch on the unread port keeps `irq_n` at 0.
- R6: If an input returns to its reference level before any read, `irq_n` goes back to 1 by itself one clock after the synchronized level reverts. A later read is not needed.
- R7: Once low, `irq_n` stays low for any number of cycles while pins, directions and strobes stay idle.
- R8: While a pin is an output, its reference follows its level. Switching it to input at a steady level does not make `irq_n` go low.
- R9: A read strobe captures the synchronized level sampled at that same edge. If the pin's synchronized level changes after that edge, `irq_n` goes low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | 16 | Raw pin levels, asynchronous |
| dir_in | input | 16 | Direction per pin, 1 = input, 0 = output |
| rd_port | input | 2 | One-cycle read strobe per 8-pin port |
| irq_n | output | 1 | Interrupt, active low, registered |

## Verification
The hardest case to reach is a read strobe that lands in the exact cycle a changed level emerges from the synchronizer. One cycle earlier, the read captures the old level and the interrupt fires right after. In that cycle itself, the read captures the new level and nothing fires. The bench reaches both cases by counting edges from the pin change and placing the strobe one cycle apart in two runs. A behavioural per-pin model, compared every cycle, confirms the interrupt level across the self-clearing pulse, the partial-port reads and the direction flips.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
    localparam int unsigned DEF_PORT_W      = 8;
    localparam int unsigned DEF_NUM_PORTS   = 2;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Port index that owns a given pin
    function automatic int unsigned port_of(input int unsigned pin, input int unsigned port_w);
        return pin / port_w;
    endfunction
endpackage

// File: rtl/gcirq_sync.sv
module gcirq_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = raw_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/gcirq_ref.sv
module gcirq_ref
    import gpio_chg_pkg::*;
#(
    parameter int unsigned PORT_W    = 8,
    parameter int unsigned NUM_PORTS = 2,
    localparam int unsigned PIN_W    = PORT_W * NUM_PORTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_W-1:0]     lvl_i,
    input  logic [PIN_W-1:0]     dir_in,
    input  logic [NUM_PORTS-1:0] rd_port,
    output logic [PIN_W-1:0]     ref_d_o,
    output logic [PIN_W-1:0]     ref_q_o
);
    typedef struct packed {
        logic [PIN_W-1:0] refv;
    } ref_st_t;

    ref_st_t st_d, st_q;
    logic [PIN_W-1:0] load_d;

    // Expand per-port read strobes to per-pin load enables
    always_comb begin
        for (int i = 0; i < int'(PIN_W); i++) begin
            load_d[i] = rd_port[port_of(i, PORT_W)] | ~dir_in[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.refv = lvl_i;
        end else begin
            for (int i = 0; i < int'(PIN_W); i++) begin
                if (load_d[i]) st_d.refv[i] = lvl_i[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ref_d_o = st_d.refv;
    assign ref_q_o = st_q.refv;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
            p_read_snap_r9: assert property (@(posedge clk) disable iff (!rst_n)
                rd_port[p] |=> (st_q.refv[p*PORT_W +: PORT_W] == $past(lvl_i[p*PORT_W +: PORT_W])));
            p_other_port_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (!rd_port[p] && (&dir_in[p*PORT_W +: PORT_W]))
                |=> $stable(st_q.refv[p*PORT_W +: PORT_W]));
        end
    endgenerate
endmodule

// File: rtl/gcirq_out.sv
module gcirq_out #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] ref_nxt_i,
    input  logic [W-1:0] dir_in,
    output logic         irq_n
);
    typedef struct packed {
        logic irq_n;
    } out_st_t;

    out_st_t st_d, st_q;
    logic [W-1:0] diff_d;

    always_comb begin
        diff_d = (lvl_i ^ ref_nxt_i) & dir_in;
        st_d   = st_q;
        if (!rst_n) begin
            st_d.irq_n = 1'b1;
        end else begin
            st_d.irq_n = ~(|diff_d);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign irq_n = st_q.irq_n;

    p_out_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in == '0) |=> irq_n);
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
    import gpio_chg_pkg::*;
#(
    parameter int unsigned PORT_W      = DEF_PORT_W,
    parameter int unsigned NUM_PORTS   = DEF_NUM_PORTS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int unsigned PIN_W      = PORT_W * NUM_PORTS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_W-1:0]     pin_in,
    input  logic [PIN_W-1:0]     dir_in,
    input  logic [NUM_PORTS-1:0] rd_port,
    output logic                 irq_n
);
    logic [PIN_W-1:0] lvl_s;
    logic [PIN_W-1:0] ref_d;
    logic [PIN_W-1:0] ref_q;

    gcirq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .raw_i  (pin_in),
        .sync_o (lvl_s)
    );

    gcirq_ref #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (lvl_s),
        .dir_in  (dir_in),
        .rd_port (rd_port),
        .ref_d_o (ref_d),
        .ref_q_o (ref_q)
    );

    gcirq_out #(.W(PIN_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (lvl_s),
        .ref_nxt_i (ref_d),
        .dir_in    (dir_in),
        .irq_n     (irq_n)
    );

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> irq_n);

    p_read_all_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&rd_port) |=> irq_n);

    p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && rd_port == '0 && $stable(lvl_s) && $stable(dir_in)) |=> !irq_n);

    p_mismatch_fires_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_port == '0 && $stable(dir_in) && (|((lvl_s ^ ref_q) & dir_in))) |=> !irq_n);
endmodule

// File: tb/gpio_chg_irq_bench.sv
`timescale 1ns/1ps
module gpio_chg_irq_bench;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pins = 16'hA5C3;
    logic [PW-1:0] dir  = 16'hFFFF;
    logic [1:0]    rd   = 2'b00;
    logic          irq_n;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_chg_irq u_gpio_chg_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pins),
        .dir_in  (dir),
        .rd_port (rd),
        .irq_n   (irq_n)
    );

    // Behavioural reference: two-deep delay line plus per-pin snapshot
    logic [PW-1:0] m_dly [2];
    logic [PW-1:0] m_ref;
    logic          m_irq;
    int            edges = 0;

    initial begin
        m_dly[0] = 16'hA5C3;
        m_dly[1] = 16'hA5C3;
        m_ref    = 16'hA5C3;
        m_irq    = 1'b1;
    end

    always @(posedge clk) begin
        logic [PW-1:0] seen;
        logic          any;
        seen = m_dly[1];
        if (!rst_n) begin
            m_ref = seen;
            m_irq = 1'b1;
        end else begin
            any = 1'b0;
            for (int i = 0; i < PW; i++) begin
                if (rd[i/8] || !dir[i]) m_ref[i] = seen[i];
                if (dir[i] && (seen[i] != m_ref[i])) any = 1'b1;
            end
            m_irq = !any;
        end
        m_dly[1] = m_dly[0];
        m_dly[0] = pins;
        edges++;
    end

    always @(negedge clk) begin
        if (edges > 0 && !done) begin
            checks++;
            if (irq_n !== m_irq) begin
                failures++;
                $display("FAIL %s cycle-compare t=%0t irq_n actual=%b expected=%b",
                         cur_req, $time, irq_n, m_irq);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_irq(logic exp, string req);
        checks++;
        if (irq_n !== exp) begin
            failures++;
            $display("FAIL %s irq_n actual=%b expected=%b", req, irq_n, exp);
        end
    endtask

    task automatic pulse_rd(logic [1:0] which);
        rd = which;
        step(1);
        rd = 2'b00;
    endtask

    initial begin
        // R1: reset state and reference load
        step(4);
        expect_irq(1'b1, "R1");
        rst_n = 1'b1;
        step(5);
        expect_irq(1'b1, "R1");

        // R2: input change latency of three edges
        cur_req = "R2";
        pins[3] = ~pins[3];
        step(2);
        expect_irq(1'b1, "R2");
        step(1);
        expect_irq(1'b0, "R2");

        // R7: stays low while idle
        cur_req = "R7";
        step(60);
        expect_irq(1'b0, "R7");

        // R4: read of port 0 clears
        cur_req = "R4";
        pulse_rd(2'b01);
        expect_irq(1'b1, "R4");
        step(3);
        expect_irq(1'b1, "R4");

        // R5: read of port 0 leaves port 1 mismatch alive
        cur_req = "R5";
        pins[10] = ~pins[10];
        pins[2]  = ~pins[2];
        step(4);
        expect_irq(1'b0, "R5");
        pulse_rd(2'b01);
        expect_irq(1'b0, "R5");
        step(3);
        expect_irq(1'b0, "R5");
        pulse_rd(2'b10);
        expect_irq(1'b1, "R5");

        // R6: short pulse self-clears, nothing remembered
        cur_req = "R6";
        pins[5] = ~pins[5];
        step(1);
        pins[5] = ~pins[5];
        step(2);
        expect_irq(1'b0, "R6");
        step(1);
        expect_irq(1'b1, "R6");
        step(10);
        expect_irq(1'b1, "R6");

        // R3: output pins masked
        cur_req = "R3";
        dir = 16'h00FF;
        step(2);
        for (int k = 0; k < 12; k++) begin
            pins[15:8] = pins[15:8] ^ 8'(k * 37 + 1);
            step(1);
        end
        step(4);
        expect_irq(1'b1, "R3");
        dir = 16'h0000;
        for (int k = 0; k < 12; k++) begin
            pins = pins ^ 16'(k * 4099 + 3);
            step(1);
        end
        step(4);
        expect_irq(1'b1, "R3");

        // R8: switching to input at steady level stays quiet
        cur_req = "R8";
        step(4);
        dir = 16'hFFFF;
        step(6);
        expect_irq(1'b1, "R8");

        // R9 case A: read lands on edge where new level is visible
        cur_req = "R9";
        pins[1] = ~pins[1];
        step(2);
        pulse_rd(2'b01);
        expect_irq(1'b1, "R9");
        step(5);
        expect_irq(1'b1, "R9");

        // R9 case B: read one edge early captures old level, then fires
        pins[1] = ~pins[1];
        step(1);
        pulse_rd(2'b01);
        expect_irq(1'b1, "R9");
        step(1);
        expect_irq(1'b0, "R9");
        pulse_rd(2'b01);
        expect_irq(1'b1, "R9");

        // Mixed pattern, model compared every cycle
        cur_req = "R2";
        for (int k = 0; k < 40; k++) begin
            pins = pins ^ (16'h1 << (k % 16));
            dir  = (k % 7 == 0) ? 16'h0F0F : 16'hFFFF;
            rd   = (k % 5 == 0) ? 2'(k % 4) : 2'b00;
            step(1);
        end
        rd = 2'b00;
        step(5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule